// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a byte-addressed serial memory on a two-wire bus. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions and takes in a device select byte, which it compares with a fixed type prefix and three strap inputs. It then serves write and read transfers against an internal byte array. It never drives the data line high. It only raises an open-drain enable that pulls the line low, and the pad and pull-up are outside the block.

A write transfer carries a two-byte word address and then data bytes. The data bytes collect in a one-page buffer and are committed to the array at the stop. A timed write cycle follows, and while it runs the block refuses to acknowledge its select byte, so a master can poll until the cycle is over. Three kinds of read are served: a read from the current address, a random read that uses an address-only write as a pointer load, and a sequential read that runs across the whole array.

Top module: `eeprom2w_slave`

## Requirements
- R1: A start is seen when SDA falls while SCL is high, and a stop when SDA rises while SCL is high. Both lines pass through a two-flop synchroniser first. A start at any point abandons the transfer in progress and discards write data not yet committed. It also releases SDA and restarts select-byte reception.
- R2: The select byte arrives MSB first. Its bits [7:4] must be 4'b1010, bits [3:1] must equal strap_i[2:0], and bit 0 selects read (1) or write (0). On a match the block pulls SDA low for the whole ninth SCL period.
- R3: On a select mismatch the block does not acknowledge. It keeps SDA released for every later bit and byte until the next start.
- R4: In a write, the byte after the select is the high address byte and the next is the low address byte. Only the low ADDR_W bits of the pair are used. Every address and data byte is acknowledged, and the data reaches the array when the stop arrives.
- R5: After each data byte of a write, the low PAGE_W address bits step by one and wrap inside the page, while the upper bits do not change. A byte written later to the same slot replaces the earlier one.
- R6: A stop that ends a write holding at least one data byte starts a write cycle of WR_CYCLES clocks. While that cycle runs, no select byte is acknowledged. An address-only write starts no cycle.
- R7: After an address-only write, a start and a read select return the byte at the newly loaded address.
- R8: A read that has no address phase returns the byte one past the last byte read or written.
- R9: During a read, each master ACK makes the block send the byte at the next address, and the address wraps from 2**ADDR_W-1 to 0. A master NACK ends the read and SDA stays released.
- R10: The SDA enable changes only in the cycle after a synchronised SCL falling edge, start or stop, so it is steady for the whole time SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Device strap bits, compared with select bits [3:1] |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Several properties are checked on every cycle. A start always returns the engine to select reception with SDA released. The SDA enable moves only right after an SCL fall, a start or a stop. No select acknowledge is given during a write cycle. A commit always launches the busy window, and a commit never happens while that window is open. Other behaviour shows only in the bench's bus scenarios. Page-offset wrap and overwrite, and address wrap at the top of the array, are seen that way. So are the current-address pointer after reads and writes, the loss of data when a repeated start cuts a write short, and the count of polls that go unacknowledged.

// File: rtl/ee_pkg.sv
package ee_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_DEV,
      S_AHI,
      S_ALO,
      S_WDAT,
      S_RDAT
   } ee_state_e;

   localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/ee_line_mon.sv
module ee_line_mon #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (SYNC_N < 2) begin : g_bad_sync
      $error("ee_line_mon: SYNC_N must be at least 2");
   end

   logic [SYNC_N-1:0] scl_sh, sda_sh;
   logic              scl_q, sda_q, scl_s, sda_s;

   assign scl_s = scl_sh[SYNC_N-1];
   assign sda_s = sda_sh[SYNC_N-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_N-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_N-2:0], sda_i};
         scl_q  <= scl_s;
         sda_q  <= sda_s;
      end
   end

   assign sda_s_o    = sda_s;
   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_store.sv
module ee_store #(
   parameter int ADDR_W    = 10,
   parameter int PAGE_W    = 5,
   parameter int WR_CYCLES = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic              clear_i,
   input  logic              commit_i,
   output logic              busy_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int SLOTS = 1 << PAGE_W;
   localparam int CW    = $clog2(WR_CYCLES + 1);

   logic [7:0]               mem  [DEPTH];
   logic [7:0]               pbuf [SLOTS];
   logic                     pval [SLOTS];
   logic [ADDR_W-PAGE_W-1:0] page_q;
   logic [CW-1:0]            cnt;
   logic                     any_val, do_commit;

   always_comb begin
      any_val = 1'b0;
      for (int i = 0; i < SLOTS; i++) any_val = any_val | pval[i];
   end
   assign do_commit = commit_i & any_val;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pval[g] <= 1'b0;
            pbuf[g] <= 8'h00;
         end else if (clear_i || do_commit) begin
            pval[g] <= 1'b0;
         end else if (wr_en_i && wr_addr_i[PAGE_W-1:0] == PAGE_W'(g)) begin
            pval[g] <= 1'b1;
            pbuf[g] <= wr_data_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_q <= '0;
      else if (wr_en_i) page_q <= wr_addr_i[ADDR_W-1:PAGE_W];
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < SLOTS; i++)
         if (do_commit && pval[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
      rd_data_o <= mem[rd_addr_i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (do_commit)   cnt <= CW'(WR_CYCLES);
      else if (cnt != '0)   cnt <= cnt - CW'(1);
   end
   assign busy_o = (cnt != '0);

   assert_commit_starts_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      do_commit |=> busy_o);
   assert_no_commit_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      do_commit |-> !busy_o);
endmodule

// File: rtl/ee_slave_fsm.sv
module ee_slave_fsm
   import ee_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [2:0]        strap_i,
   input  logic              busy_i,
   input  logic [7:0]        rd_data_i,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              clear_o,
   output logic              commit_o,
   output logic              sda_oe_o
);
   ee_state_e         st;
   logic [3:0]        bitcnt;
   logic [7:0]        shreg, ahi, txq, nb;
   logic [15:0]       full16;
   logic [PAGE_W-1:0] lo_nxt;
   logic [2:0]        tx_idx;
   logic              ack_q, is_rd, mack_q, oe;
   logic [ADDR_W-1:0] ptr;

   always_comb begin
      nb       = {shreg[6:0], sda_i};
      full16   = {ahi, nb};
      lo_nxt   = ptr[PAGE_W-1:0] + PAGE_W'(1);
      tx_idx   = 3'(4'd7 - bitcnt);
      commit_o = stop_i && (st == S_WDAT);
      clear_o  = start_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  bitcnt <= '0;  shreg <= '0;  ahi <= '0;  txq <= '0;
         ack_q <= 1'b0; is_rd <= 1'b0; mack_q <= 1'b0; oe <= 1'b0;
         ptr <= '0;     wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_i) begin
            st <= S_DEV;  bitcnt <= '0;  oe <= 1'b0;
         end else if (stop_i) begin
            st <= S_IDLE; bitcnt <= '0;  oe <= 1'b0;
         end else if (st != S_IDLE) begin
            if (scl_rise_i) begin
               if (bitcnt < 4'd8) begin
                  shreg  <= nb;
                  bitcnt <= bitcnt + 4'd1;
                  if (bitcnt == 4'd7) begin
                     case (st)
                        S_DEV: begin
                           ack_q <= (nb[7:4] == DEV_TYPE) && (nb[3:1] == strap_i) && !busy_i;
                           is_rd <= nb[0];
                        end
                        S_AHI: begin ahi <= nb; ack_q <= 1'b1; end
                        S_ALO: begin ptr <= full16[ADDR_W-1:0]; ack_q <= 1'b1; end
                        S_WDAT: begin
                           wr_en_o   <= 1'b1;
                           wr_addr_o <= ptr;
                           wr_data_o <= nb;
                           ptr       <= {ptr[ADDR_W-1:PAGE_W], lo_nxt};
                           ack_q     <= 1'b1;
                        end
                        default: ack_q <= 1'b0;
                     endcase
                  end
               end else if (bitcnt == 4'd8) begin
                  bitcnt <= 4'd9;
                  if (st == S_RDAT) begin
                     mack_q <= !sda_i;
                     ptr    <= ptr + ADDR_W'(1);
                  end
               end
            end else if (scl_fall_i) begin
               if (bitcnt == 4'd8) begin
                  oe <= (st != S_RDAT) && ack_q;
               end else if (bitcnt == 4'd9) begin
                  bitcnt <= '0;
                  oe     <= 1'b0;
                  case (st)
                     S_DEV: begin
                        if (!ack_q) st <= S_IDLE;
                        else if (is_rd) begin
                           st  <= S_RDAT;
                           txq <= rd_data_i;
                           oe  <= !rd_data_i[7];
                        end else st <= S_AHI;
                     end
                     S_AHI: st <= S_ALO;
                     S_ALO: st <= S_WDAT;
                     S_RDAT: begin
                        if (mack_q) begin
                           txq <= rd_data_i;
                           oe  <= !rd_data_i[7];
                        end else st <= S_IDLE;
                     end
                     default: st <= st;
                  endcase
               end else if (st == S_RDAT && bitcnt != 4'd0) begin
                  oe <= !txq[tx_idx];
               end
            end
         end
      end
   end

   assign ptr_o    = ptr;
   assign sda_oe_o = oe;

   assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (st == S_DEV && bitcnt == 4'd0 && !sda_oe_o));
   assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> !sda_oe_o);
   assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DEV && bitcnt == 4'd8 && sda_oe_o) |-> !busy_i);
   assert_oe_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));
endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave #(
   parameter int ADDR_W    = 10,
   parameter int PAGE_W    = 5,
   parameter int WR_CYCLES = 1000,
   parameter int SYNC_N    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   output logic       sda_oe_o
);
   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_aw
      $error("eeprom2w_slave: ADDR_W must lie in 8..16");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_pw
      $error("eeprom2w_slave: PAGE_W must lie in 1..ADDR_W-1");
   end
   if (WR_CYCLES < 1) begin : g_bad_wc
      $error("eeprom2w_slave: WR_CYCLES must be positive");
   end

   logic              sda_s, scl_rise, scl_fall, start, stop;
   logic              busy, wr_en, clear, commit;
   logic [7:0]        rd_data, wr_data;
   logic [ADDR_W-1:0] ptr, wr_addr;

   ee_line_mon #(.SYNC_N(SYNC_N)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start), .stop_o(stop)
   );

   ee_slave_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_i(sda_s), .scl_rise_i(scl_rise),
      .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop), .strap_i(strap_i),
      .busy_i(busy), .rd_data_i(rd_data), .ptr_o(ptr), .wr_en_o(wr_en),
      .wr_addr_o(wr_addr), .wr_data_o(wr_data), .clear_o(clear),
      .commit_o(commit), .sda_oe_o(sda_oe_o)
   );

   ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_addr_i(ptr), .rd_data_o(rd_data),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .clear_i(clear), .commit_i(commit), .busy_o(busy)
   );
endmodule

// File: tb/eeprom2w_slave_test.sv
module eeprom2w_slave_test;
   localparam int AW = 9;
   localparam int PW = 3;
   localparam int WC = 300;
   localparam int Q  = 4;
   localparam logic [7:0] SEL_W = 8'hAA;  // 1010 101 0
   localparam logic [7:0] SEL_R = 8'hAB;

   logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
   logic [2:0] strap = 3'b101;
   logic       sda_oe, sda_bus;
   int         total = 0, bad = 0;
   logic [7:0] got [16];
   logic [7:0] pexp [8];

   assign sda_bus = sda_m & ~sda_oe;
   always #5 clk = ~clk;

   eeprom2w_slave #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WC)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .strap_i(strap), .sda_oe_o(sda_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
      end
      sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      ack = ~sda_bus;
      tick(Q); scl = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] d);
      logic a, b;
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; tick(Q); scl = 1'b1; tick(1);
         a = sda_bus; tick(2*Q-2);
         b = sda_bus; d[i] = b; tick(1); scl = 1'b0;
         chk("R10 data steady while SCL high", int'(a), int'(b));
      end
      sda_m = ~mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic set_addr(input int addr);
      logic ack;
      bus_start();
      send_byte(SEL_W, ack);                 chk("R2 write select ack", int'(ack), 1);
      send_byte(8'((addr >> 8) & 255), ack); chk("R4 high address ack", int'(ack), 1);
      send_byte(8'(addr & 255), ack);        chk("R4 low address ack", int'(ack), 1);
   endtask

   task automatic poll_done();
      logic ack;
      int   tries;
      tries = 0;
      ack   = 1'b0;
      while (!ack && tries < 40) begin
         bus_start(); send_byte(SEL_W, ack); bus_stop(); tick(2*Q);
         tries++;
         if (tries == 1) chk("R6 select refused during write cycle", int'(ack), 0);
      end
      chk("R6 select accepted after write cycle", int'(ack), 1);
   endtask

   task automatic wr_seq(input int addr, input int n, input int base);
      logic ack;
      set_addr(addr);
      for (int k = 0; k < n; k++) begin
         send_byte(8'(base + k), ack); chk("R4 data byte ack", int'(ack), 1);
      end
      bus_stop(); tick(2*Q);
      poll_done();
   endtask

   task automatic rd_seq(input logic with_addr, input int addr, input int n);
      logic ack;
      if (with_addr) set_addr(addr);
      bus_start();
      send_byte(SEL_R, ack); chk("R2 read select ack", int'(ack), 1);
      for (int k = 0; k < n; k++) recv_byte(k < n - 1, got[k]);
      chk("R9 bus released after master NACK", int'(sda_oe), 0);
      bus_stop(); tick(2*Q);
   endtask

   initial begin
      logic ack;
      tick(5);
      chk("R3 released in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      tick(5);

      // R2 / R3: wrong strap bits, then wrong type prefix
      bus_start();
      send_byte(8'hA6, ack); chk("R2 strap mismatch gives no ack", int'(ack), 0);
      send_byte(8'h00, ack); chk("R3 later byte ignored after mismatch", int'(ack), 0);
      bus_stop();
      bus_start();
      send_byte(8'hBA, ack); chk("R2 prefix mismatch gives no ack", int'(ack), 0);
      bus_stop(); tick(2*Q);

      // R6: address-only write starts no write cycle
      set_addr(16'h0010); bus_stop(); tick(2*Q);
      bus_start(); send_byte(SEL_W, ack);
      chk("R6 no write cycle after address-only write", int'(ack), 1);
      bus_stop(); tick(2*Q);

      // R4 / R7: byte write then random read, high byte matters (0x123)
      wr_seq(16'h0123, 1, 8'h5C);
      rd_seq(1'b1, 16'h0123, 1);
      chk("R7 random read of 0x123", int'(got[0]), 8'h5C);
      wr_seq(16'h0023, 1, 8'hA5);
      rd_seq(1'b1, 16'h0123, 1);
      chk("R4 high address byte selects location", int'(got[0]), 8'h5C);

      // R5: ten bytes from page offset 5 wrap inside an 8-byte page
      for (int o = 0; o < 8; o++) pexp[o] = 8'h00;
      for (int k = 0; k < 10; k++) pexp[(5 + k) % 8] = 8'(8'h30 + k);
      wr_seq(16'h00F5, 10, 8'h30);
      rd_seq(1'b1, 16'h00F0, 8);
      for (int o = 0; o < 8; o++) chk("R5 page wrap and overwrite", int'(got[o]), int'(pexp[o]));

      // R8: current address read follows the last byte accessed
      rd_seq(1'b1, 16'h00F2, 1);
      chk("R7 random read 0xF2", int'(got[0]), int'(pexp[2]));
      rd_seq(1'b0, 0, 1);
      chk("R8 current read after read", int'(got[0]), int'(pexp[3]));
      wr_seq(16'h0124, 1, 8'h6D);
      rd_seq(1'b1, 16'h0123, 1);
      rd_seq(1'b0, 0, 1);
      chk("R8 current read returns 0x124", int'(got[0]), 8'h6D);

      // R9: sequential read across the top of the array
      wr_seq(16'h01FF, 2, 8'hE1);   // 0x1FF=E1, page wrap puts E2 at 0x1F8
      wr_seq(16'h0000, 2, 8'h77);
      rd_seq(1'b1, 16'h01FF, 3);
      chk("R9 byte at 0x1FF", int'(got[0]), 8'hE1);
      chk("R9 wrap to 0x000", int'(got[1]), 8'h77);
      chk("R9 continue at 0x001", int'(got[2]), 8'h78);
      rd_seq(1'b1, 16'h01F8, 1);
      chk("R5 page wrap at top page", int'(got[0]), 8'hE2);

      // R1: repeated start abandons an unfinished write
      wr_seq(16'h0050, 1, 8'h11);
      set_addr(16'h0050);
      send_byte(8'h99, ack); chk("R4 data ack before abort", int'(ack), 1);
      bus_start();
      send_byte(SEL_W, ack); chk("R1 restart accepts select, no write cycle", int'(ack), 1);
      bus_stop(); tick(2*Q);
      rd_seq(1'b1, 16'h0050, 1);
      chk("R1 aborted data discarded", int'(got[0]), 8'h11);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(150000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule